// File: doc/BRIEF.md
# Vector Saturating Narrow-Interleave Unit

This block carries out one vector operation: it takes two source vectors of signed 32-bit elements, clamps every element to the signed 16-bit range, and writes the narrowed values into a single destination vector of 16-bit lanes. The lanes alternate between the two sources. Even lanes come from the first source and odd lanes come from the second. Every lane is written on every operation, because the operation has no predicate.

A small decode front end checks each 32-bit instruction word against the fixed opcode pattern. It also extracts the register indices. The source pair is always an even register followed by the next register up, and the unit gives both read indices out combinationally so that an external register file can supply the two vectors in the same cycle.

The result is registered one cycle later. It comes with one of three outcome flags: valid, undefined (the feature is disabled) or no-match. It also carries a flag that is set when any lane was clamped. The vector length is a parameter that must be a multiple of 128 between 128 and 2048, and it is checked at elaboration.

Top module: `vnarrow_unit`

## Requirements
- R1: A source element greater than 32767 produces the lane value 16'h7FFF, and this includes 32'h7FFFFFFF.
- R2: A source element below -32768 produces 16'h8000, and this includes 32'h80000000. An element within [-32768, 32767] is passed through unchanged as its low 16 bits.
- R3: Destination lane k occupies bits [16k+15:16k] of `res_data`. Lane 2e takes narrowed element e of `src_a`, and lane 2e+1 takes narrowed element e of `src_b`. Element e of a source occupies bits [32e+31:32e].
- R4: An accepted operation rewrites all VL/16 destination lanes, and no lane keeps a value from an earlier result.
- R5: The read indices are `rd_idx_a = {instr[9:6],1'b0}` and `rd_idx_b = {instr[9:6],1'b1}`, driven combinationally. The destination index `instr[4:0]` is reported on `res_dst` with the result.
- R6: A word matches only when instr[31:10] equals 22'b0100010100110001010000 and instr[5] is 0. An issued word that does not match raises `res_nomatch` for one cycle, keeps `res_valid` low and leaves `res_data` unchanged.
- R7: A matching word issued while `feat_en` is low raises `res_undef` for one cycle, keeps `res_valid` low and leaves `res_data` unchanged.
- R8: The outcome flags are registered and appear in the cycle after `in_valid` is sampled. Without `in_valid`, all three flags are low in the next cycle. At most one flag is high at a time.
- R9: `res_sat` is 1 with a valid result exactly when at least one lane was clamped.
- R10: While `rst` is high, all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction word is being issued this cycle |
| feat_en | input | 1 | Feature enable; when low, a matching word is undefined |
| instr | input | 32 | Instruction word |
| src_a | input | VL | First source vector, read from register rd_idx_a |
| src_b | input | VL | Second source vector, read from register rd_idx_b |
| rd_idx_a | output | 5 | Read index of the first (even) source register |
| rd_idx_b | output | 5 | Read index of the second (odd) source register |
| res_valid | output | 1 | A result was produced |
| res_undef | output | 1 | A matching word was rejected because the feature is disabled |
| res_nomatch | output | 1 | The issued word did not match the opcode pattern |
| res_data | output | VL | Narrowed and interleaved destination vector |
| res_sat | output | 1 | At least one lane was clamped |
| res_dst | output | 5 | Destination register index |

## Verification
Assertions check the following on every cycle:
- The three outcome flags are mutually exclusive.
- A valid or undefined outcome traces back to an issue with the matching enable state.
- The result data holds whenever no valid result is produced.
- The read indices form an even/odd pair.
- Every clamped lane keeps the sign of its source, and every unclamped lane sign-extends back to its source.

Only the bench's scenarios can show that the clamp happens at exactly the right thresholds, that lanes land in the interleaved order, and that every opcode bit takes part in matching. To do this, the bench sweeps boundary values through every lane position, all Zn values and every single-bit corruption of the fixed fields.

// File: rtl/vnarrow_pkg.sv
package vnarrow_pkg;
  localparam int INSTR_W  = 32;
  localparam int WIDE_W   = 32;
  localparam int NARROW_W = 16;
  localparam int IDX_W    = 5;
  localparam int ZN_W     = 4;
  localparam int OPC_W    = 22;
  localparam logic [OPC_W-1:0] OPC_FIXED = 22'b0100010100110001010000;

  typedef struct packed {
    logic [IDX_W-1:0] rd_a;
    logic [IDX_W-1:0] rd_b;
    logic [IDX_W-1:0] dst;
  } vn_regs_t;
endpackage

// File: rtl/vnarrow_decode.sv
module vnarrow_decode
  import vnarrow_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic               match,
  output vn_regs_t           regs
);
  logic [ZN_W-1:0] zn;

  always_comb begin
    match     = (instr[INSTR_W-1:INSTR_W-OPC_W] == OPC_FIXED) && !instr[5];
    zn        = instr[9:6];
    regs.rd_a = {zn, 1'b0};
    regs.rd_b = {zn, 1'b1};
    regs.dst  = instr[4:0];
  end

  always_comb begin
    AST_IDX_PAIR: assert (regs.rd_a[0] == 1'b0 && regs.rd_b == regs.rd_a + 1'b1); // R5
  end
endmodule

// File: rtl/vnarrow_sat.sv
module vnarrow_sat #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout,
  output logic             clamped
);
  localparam logic [IN_W-1:0] HI = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic [IN_W-1:0] LO = ~HI;

  always_comb begin
    if ($signed(din) > $signed(HI)) begin
      dout    = HI[OUT_W-1:0];
      clamped = 1'b1;
    end else if ($signed(din) < $signed(LO)) begin
      dout    = LO[OUT_W-1:0];
      clamped = 1'b1;
    end else begin
      dout    = din[OUT_W-1:0];
      clamped = 1'b0;
    end
  end

  always_comb begin
    AST_CLAMP_SIGN: assert (!clamped || dout[OUT_W-1] == din[IN_W-1]); // R1
    AST_PASS_EXACT: assert (clamped || {{(IN_W-OUT_W){dout[OUT_W-1]}}, dout} == din); // R2
  end
endmodule

// File: rtl/vnarrow_lanes.sv
module vnarrow_lanes
  import vnarrow_pkg::*;
#(
  parameter int VL = 128
) (
  input  logic [VL-1:0] src_a,
  input  logic [VL-1:0] src_b,
  output logic [VL-1:0] dst,
  output logic          any_sat
);
  localparam int NELEM = VL / WIDE_W;
  localparam int NLANE = 2 * NELEM;

  logic [NLANE-1:0] lane_clamp;

  for (genvar e = 0; e < NELEM; e++) begin : g_elem
    for (genvar i = 0; i < 2; i++) begin : g_src
      logic [WIDE_W-1:0] wide;
      if (i == 0) begin : g_a
        assign wide = src_a[e*WIDE_W +: WIDE_W];
      end else begin : g_b
        assign wide = src_b[e*WIDE_W +: WIDE_W];
      end
      vnarrow_sat #(.IN_W(WIDE_W), .OUT_W(NARROW_W)) i_sat (
        .din     (wide),
        .dout    (dst[(2*e+i)*NARROW_W +: NARROW_W]),
        .clamped (lane_clamp[2*e+i])
      );
    end
  end

  assign any_sat = |lane_clamp;
endmodule

// File: rtl/vnarrow_unit.sv
module vnarrow_unit
  import vnarrow_pkg::*;
#(
  parameter int VL = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               feat_en,
  input  logic [INSTR_W-1:0] instr,
  input  logic [VL-1:0]      src_a,
  input  logic [VL-1:0]      src_b,
  output logic [IDX_W-1:0]   rd_idx_a,
  output logic [IDX_W-1:0]   rd_idx_b,
  output logic               res_valid,
  output logic               res_undef,
  output logic               res_nomatch,
  output logic [VL-1:0]      res_data,
  output logic               res_sat,
  output logic [IDX_W-1:0]   res_dst
);
  if (VL % 128 != 0 || VL < 128 || VL > 2048) begin : g_bad_vl
    $error("vnarrow_unit: VL must be a multiple of 128 in [128, 2048]");
  end

  logic          match;
  vn_regs_t      regs;
  logic [VL-1:0] narrow;
  logic          any_sat;
  logic          accept;

  vnarrow_decode i_decode (
    .instr (instr),
    .match (match),
    .regs  (regs)
  );

  vnarrow_lanes #(.VL(VL)) i_lanes (
    .src_a   (src_a),
    .src_b   (src_b),
    .dst     (narrow),
    .any_sat (any_sat)
  );

  assign rd_idx_a = regs.rd_a;
  assign rd_idx_b = regs.rd_b;
  assign accept   = in_valid && match && feat_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_undef   <= 1'b0;
      res_nomatch <= 1'b0;
      res_data    <= '0;
      res_sat     <= 1'b0;
      res_dst     <= '0;
    end else begin
      res_valid   <= accept;
      res_undef   <= in_valid && match && !feat_en;
      res_nomatch <= in_valid && !match;
      if (accept) begin
        res_data <= narrow;
        res_sat  <= any_sat;
        res_dst  <= regs.dst;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $countones({res_valid, res_undef, res_nomatch}) <= 1); // R8
  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid && feat_en)); // R8
  AST_UNDEF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    res_undef |-> $past(in_valid && !feat_en)); // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(res_data)); // R6
endmodule

// File: tb/test_vnarrow_unit.sv
module test_vnarrow_unit;
  localparam int VL    = 128;
  localparam int NELEM = VL / 32;
  localparam int NLANE = VL / 16;
  localparam logic [21:0] OPC = 22'b0100010100110001010000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          feat_en = 1'b1;
  logic [31:0]   instr = '0;
  logic [VL-1:0] src_a = '0;
  logic [VL-1:0] src_b = '0;
  logic [4:0]    rd_idx_a, rd_idx_b, res_dst;
  logic          res_valid, res_undef, res_nomatch, res_sat;
  logic [VL-1:0] res_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;

  vnarrow_unit #(.VL(VL)) i_vnarrow_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .feat_en(feat_en), .instr(instr),
    .src_a(src_a), .src_b(src_b), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
    .res_valid(res_valid), .res_undef(res_undef), .res_nomatch(res_nomatch),
    .res_data(res_data), .res_sat(res_sat), .res_dst(res_dst)
  );

  function automatic logic [15:0] ref_sat(input logic [31:0] v);
    if ($signed(v) > 32767) return 16'h7FFF;
    if ($signed(v) < -32768) return 16'h8000;
    return v[15:0];
  endfunction

  function automatic logic ref_clamps(input logic [31:0] v);
    return ($signed(v) > 32767) || ($signed(v) < -32768);
  endfunction

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input logic [VL-1:0] act,
                       input logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] make_instr(input logic [3:0] zn, input logic [4:0] zd);
    return {OPC, zn, 1'b0, zd};
  endfunction

  // Issues one matching, enabled operation and checks the result, R1 R2 R3 R4 R9.
  task automatic run_op(input logic [VL-1:0] a, input logic [VL-1:0] b, input string tag);
    logic [VL-1:0] exp;
    logic          esat;
    esat = 1'b0;
    for (int k = 0; k < NLANE; k++) begin
      logic [31:0] w;
      w = (k % 2 == 0) ? a[(k/2)*32 +: 32] : b[(k/2)*32 +: 32];
      exp[k*16 +: 16] = ref_sat(w);
      esat = esat | ref_clamps(w);
    end
    @(negedge clk);
    in_valid = 1'b1; feat_en = 1'b1; instr = make_instr(4'd3, 5'd9);
    src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(res_valid === 1'b1, {"R8 valid ", tag}, {{(VL-1){1'b0}}, res_valid}, 1);
    check(res_data === exp, {"R1/R2/R3/R4 data ", tag}, res_data, exp);
    check(res_sat === esat, {"R9 sat ", tag}, {{(VL-1){1'b0}}, res_sat},
          {{(VL-1){1'b0}}, esat});
  endtask

  logic [31:0] bvals [12];

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [VL-1:0] held;
    bvals[0] = 32'd32767;       bvals[1] = 32'd32768;
    bvals[2] = -32'sd32768;     bvals[3] = -32'sd32769;
    bvals[4] = 32'h7FFF_FFFF;   bvals[5] = 32'h8000_0000;
    bvals[6] = 32'd0;           bvals[7] = 32'hFFFF_FFFF;
    bvals[8] = 32'd65535;       bvals[9] = -32'sd65536;
    bvals[10] = 32'd12345;      bvals[11] = 32'h0001_0000;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(res_valid === 0 && res_undef === 0 && res_nomatch === 0 && res_sat === 0
          && res_data === '0 && res_dst === '0, "R10 reset", res_data, '0);
    rst = 1'b0;

    // R5: read and destination indices for every Zn
    for (int zn = 0; zn < 16; zn++) begin
      @(negedge clk);
      instr = make_instr(zn[3:0], 5'(31 - zn)); in_valid = 1'b1; feat_en = 1'b1;
      #1;
      check(rd_idx_a === 5'(2*zn) && rd_idx_b === 5'(2*zn + 1), "R5 rd idx",
            {rd_idx_a, rd_idx_b}, {5'(2*zn), 5'(2*zn + 1)});
      @(negedge clk);
      check(res_dst === 5'(31 - zn), "R5 dst", res_dst, 5'(31 - zn));
      in_valid = 1'b0;
    end

    // R1 R2 R3: each boundary value through every lane position
    for (int v = 0; v < 12; v++) begin
      for (int lane = 0; lane < NLANE; lane++) begin
        logic [VL-1:0] a, b;
        for (int e = 0; e < NELEM; e++) begin
          a[e*32 +: 32] = 32'(100 + e);
          b[e*32 +: 32] = -32'(200 + e);
        end
        if (lane % 2 == 0) a[(lane/2)*32 +: 32] = bvals[v];
        else               b[(lane/2)*32 +: 32] = bvals[v];
        run_op(a, b, "boundary");
      end
    end

    // R4 R9: all lanes clamped, then none
    run_op({NELEM{32'h7FFF_FFFF}}, {NELEM{32'h8000_0000}}, "all sat");
    run_op({NELEM{32'd5}}, {NELEM{-32'sd7}}, "none sat");

    // R1 R2 R3 R9: pseudorandom mixes of magnitudes
    for (int n = 0; n < 300; n++) begin
      logic [VL-1:0] a, b;
      for (int e = 0; e < NELEM; e++) begin
        rng = next_rng(rng);
        a[e*32 +: 32] = 32'($signed(rng) >>> (rng[4:0] % 20));
        rng = next_rng(rng);
        b[e*32 +: 32] = 32'($signed(rng) >>> (rng[4:0] % 20));
      end
      run_op(a, b, "random");
    end

    // R8: no issue means no outcome the next cycle
    @(negedge clk);
    check(res_valid === 0 && res_undef === 0 && res_nomatch === 0, "R8 idle",
          {res_valid, res_undef, res_nomatch}, 0);

    // R6: every single-bit corruption of fixed fields
    held = res_data;
    for (int bit_i = 5; bit_i < 32; bit_i++) begin
      if (bit_i >= 6 && bit_i <= 9) continue;
      @(negedge clk);
      instr = make_instr(4'd1, 5'd2) ^ (32'd1 << bit_i);
      src_a = {NELEM{32'h7FFF_FFFF}}; src_b = '0;
      in_valid = 1'b1; feat_en = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(res_nomatch === 1 && res_valid === 0 && res_undef === 0, "R6 nomatch flags",
            {res_nomatch, res_valid, res_undef}, 3'b100);
      check(res_data === held, "R6 data held", res_data, held);
    end

    // R7: feature disabled
    @(negedge clk);
    instr = make_instr(4'd2, 5'd4); src_a = {NELEM{32'h8000_0000}};
    in_valid = 1'b1; feat_en = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; feat_en = 1'b1;
    check(res_undef === 1 && res_valid === 0 && res_nomatch === 0, "R7 undef flags",
          {res_undef, res_valid, res_nomatch}, 3'b100);
    check(res_data === held, "R7 data held", res_data, held);
    @(negedge clk);
    check(res_undef === 0, "R8 undef one cycle", {{(VL-1){1'b0}}, res_undef}, 0);

    // R10: reset after activity
    run_op({NELEM{32'h7FFF_FFFF}}, '0, "pre-reset");
    rst = 1'b1;
    @(negedge clk);
    check(res_valid === 0 && res_sat === 0 && res_data === '0, "R10 re-reset", res_data, '0);
    rst = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule